// File: doc/BRIEF.md
# RV64 Integer Execute Unit with 32-bit Word Forms

This block is the combinational integer execute stage of a 64-bit base-integer core. It takes two 64-bit operands, the program counter of the current instruction, a 4-bit operation select and a word-mode flag. It returns a 64-bit result in the same cycle. The decoder in front of it passes either register values or immediates as operands. For LUI and AUIPC it passes the 20-bit upper immediate in operand B bits 19:0.

The low three bits of the operation select follow the usual integer function-code layout. Bit 3 is an alternate-form bit, in the same position as instruction bit 30. For add it selects subtract. For the right shift it selects arithmetic instead of logical. For the two compare codes it selects LUI or AUIPC, which reuse those two free slots. When the word flag is set, add, subtract and the three shifts work on the low 32 bits only and sign-extend their 32-bit result.

Top module: `rv64_exec_alu`

## Requirements
- R1: Encoding of op_sel_i[2:0]: 0 add/sub, 1 shift left, 2 signed less-than, 3 unsigned less-than, 4 xor, 5 right shift, 6 or, 7 and. With word_i low, add returns opa+opb modulo 2^64, and op_sel_i=4'b1000 returns opa-opb modulo 2^64.
- R2: With word_i high, add/sub return bits 31:0 of the sum or difference, and bits 63:32 repeat bit 31. Overflow is dropped. Adding a zero operand B gives the sign extension of opa[31:0].
- R3: Full-width shifts (codes 1 and 5, word_i low) take the amount from opb[5:0] only and ignore opb[63:6].
- R4: Word shifts (word_i high) shift opa[31:0] by opb[4:0], ignore opa[63:32] and opb[63:5], and sign-extend bit 31 of the 32-bit result.
- R5: Left shifts and logical right shifts (op_sel_i=4'b0101) fill with zeros. The arithmetic right shift (op_sel_i=4'b1101) fills with bit 63, or with bit 31 in word mode.
- R6: Codes 2 and 3 with bit 3 low return 1 in bit 0 when opa is less than opb, as signed and as unsigned 64-bit values respectively. All other result bits are zero.
- R7: Codes 4, 6 and 7 return the bitwise xor, or and and of the full operands. Bit 3 has no effect on codes 1, 4, 6 and 7.
- R8: word_i has no effect on codes 2, 3, 4, 6, 7, or on LUI and AUIPC.
- R9: LUI (op_sel_i=4'b1010) returns opb[19:0] placed in bits 31:12, with bits 11:0 zero and bit 31 copied into bits 63:32.
- R10: AUIPC (op_sel_i=4'b1011) returns pc_i plus the value LUI would form, modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel_i | input | 4 | Operation select: bit 3 alternate form, bits 2:0 operation code |
| word_i | input | 1 | 32-bit word form for add/sub and shifts |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand, shift amount or upper immediate |
| pc_i | input | 64 | Address of the current instruction, used by AUIPC |
| result_o | output | 64 | Operation result |

## Verification
The block has no registers, so every result belongs to the inputs of that same cycle. The bench changes the inputs on the falling clock edge and compares result_o two nanoseconds later, well before the next rising edge. The corner-value sweep covers all sixteen select codes in both word modes. A second sweep steps every shift amount from 0 to 63 while junk bits sit above the amount field, which tests the masking rules.

// File: rtl/rv64_alu_pkg.sv
// Package: shared operation codes for the integer execute unit.
// Assumes: op select bits 2:0 carry the function code, bit 3 the alternate form.
package rv64_alu_pkg;
    typedef enum logic [2:0] {
        K_ADD  = 3'd0,
        K_SLL  = 3'd1,
        K_SLT  = 3'd2,
        K_SLTU = 3'd3,
        K_XOR  = 3'd4,
        K_SRX  = 3'd5,
        K_OR   = 3'd6,
        K_AND  = 3'd7
    } alu_kind_e;

    localparam logic [3:0] OP_SUB   = 4'b1000;
    localparam logic [3:0] OP_LUI   = 4'b1010;
    localparam logic [3:0] OP_AUIPC = 4'b1011;
endpackage

// File: rtl/rv64_alu_adder.sv
// Module: shared adder. Subtracts by adding the inverted B operand plus one.
// Assumes: the caller muxes the operands; carry out is not needed.
module rv64_alu_adder #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] b_eff;
    logic [W-1:0] cin;

    // Condition B and the carry-in for add or subtract
    always_comb begin
        b_eff = b_i ^ {W{sub_i}};
        cin   = {{(W-1){1'b0}}, sub_i};
    end

    // Single carry chain
    always_comb begin
        sum_o = a_i + b_eff + cin;
    end
endmodule

// File: rtl/rv64_alu_compare.sv
// Module: signed and unsigned less-than over full-width operands.
// Assumes: pure combinational use; outputs are single flags.
module rv64_alu_compare #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         lt_s_o,
    output logic         lt_u_o
);
    // Unsigned compare first, signed compare fixes up differing signs
    always_comb begin
        lt_u_o = (a_i < b_i);
        lt_s_o = (a_i[W-1] ^ b_i[W-1]) ? a_i[W-1] : lt_u_o;
    end
endmodule

// File: rtl/rv64_alu_shifter.sv
// Module: full-width and word shifter sharing one left and one right shifter.
// Assumes: in word mode only the low WLEN bits of A and the low log2(WLEN)
// bits of the amount matter; the word result is sign-extended.
module rv64_alu_shifter #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic [XLEN-1:0]         a_i,
    input  logic [$clog2(XLEN)-1:0] amt_i,
    input  logic                    right_i,
    input  logic                    arith_i,
    input  logic                    word_i,
    output logic [XLEN-1:0]         res_o
);
    localparam int SHW  = $clog2(XLEN);
    localparam int WSHW = $clog2(WLEN);
    localparam int HIW  = XLEN - WLEN;

    logic [SHW-1:0]  amt;
    logic [XLEN-1:0] src;
    logic            fill;
    logic [XLEN:0]   right_wide;
    logic [XLEN-1:0] raw;

    // Pick the amount field width for the mode
    always_comb begin
        amt = word_i ? {{(SHW-WSHW){1'b0}}, amt_i[WSHW-1:0]} : amt_i;
    end

    // Pre-extend the word source so one right shifter serves both widths
    always_comb begin
        src  = word_i ? {{HIW{arith_i & a_i[WLEN-1]}}, a_i[WLEN-1:0]} : a_i;
        fill = arith_i & src[XLEN-1];
    end

    // Shift, then fold the word result back to a sign-extended value
    always_comb begin
        right_wide = $unsigned($signed({fill, src}) >>> amt);
        raw        = right_i ? right_wide[XLEN-1:0] : (a_i << amt);
        res_o      = word_i ? {{HIW{raw[WLEN-1]}}, raw[WLEN-1:0]} : raw;
    end
endmodule

// File: rtl/rv64_exec_alu.sv
// Module: combinational integer execute unit with 32-bit word forms.
// Assumes: no clock or reset (purely combinational); LUI/AUIPC immediate in
// opb_i[19:0]; WORD_OPS=0 builds a variant without word forms.
module rv64_exec_alu
    import rv64_alu_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int WLEN     = 32,
    parameter int UIMM_W   = 20,
    parameter bit WORD_OPS = 1'b1
) (
    input  logic [3:0]      op_sel_i,
    input  logic            word_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] result_o
);
    localparam int SHW  = $clog2(XLEN);
    localparam int HIW  = XLEN - WLEN;
    localparam int LOWZ = WLEN - UIMM_W;

    alu_kind_e       kind;
    logic            alt;
    logic            is_lui;
    logic            is_auipc;
    logic            word_ok;
    logic            use_word;
    logic [XLEN-1:0] uimm;
    logic [XLEN-1:0] add_a;
    logic [XLEN-1:0] add_b;
    logic            add_sub;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] sum_sel;
    logic            lt_s;
    logic            lt_u;
    logic [XLEN-1:0] shift_res;

    // Decode the select into kind, alternate form and upper-immediate ops
    always_comb begin
        kind     = alu_kind_e'(op_sel_i[2:0]);
        alt      = op_sel_i[3];
        is_lui   = (op_sel_i == OP_LUI);
        is_auipc = (op_sel_i == OP_AUIPC);
        word_ok  = (kind == K_ADD) || (kind == K_SLL) || (kind == K_SRX);
        use_word = WORD_OPS && word_i && word_ok;
    end

    // Form the sign-extended upper immediate
    always_comb begin
        uimm = {{HIW{opb_i[UIMM_W-1]}}, opb_i[UIMM_W-1:0], {LOWZ{1'b0}}};
    end

    // Steer the shared adder: AUIPC borrows it for pc + immediate
    always_comb begin
        add_a   = is_auipc ? pc_i : opa_i;
        add_b   = is_auipc ? uimm : opb_i;
        add_sub = alt && (kind == K_ADD);
    end

    rv64_alu_adder #(.W(XLEN)) i_adder (
        .a_i   (add_a),
        .b_i   (add_b),
        .sub_i (add_sub),
        .sum_o (sum)
    );

    rv64_alu_compare #(.W(XLEN)) i_compare (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    rv64_alu_shifter #(.XLEN(XLEN), .WLEN(WLEN)) i_shifter (
        .a_i     (opa_i),
        .amt_i   (opb_i[SHW-1:0]),
        .right_i (kind == K_SRX),
        .arith_i (alt),
        .word_i  (use_word),
        .res_o   (shift_res)
    );

    // Word-form narrowing of the adder output, present only when enabled
    generate
        if (WORD_OPS) begin : g_word_sum
            always_comb begin
                sum_sel = use_word ? {{HIW{sum[WLEN-1]}}, sum[WLEN-1:0]} : sum;
            end
        end else begin : g_full_sum
            always_comb begin
                sum_sel = sum;
            end
        end
    endgenerate

    // Final result selection
    always_comb begin
        if (is_lui) begin
            result_o = uimm;
        end else if (is_auipc) begin
            result_o = sum;
        end else begin
            unique case (kind)
                K_ADD:   result_o = sum_sel;
                K_SLL:   result_o = shift_res;
                K_SRX:   result_o = shift_res;
                K_SLT:   result_o = {{(XLEN-1){1'b0}}, lt_s};
                K_SLTU:  result_o = {{(XLEN-1){1'b0}}, lt_u};
                K_XOR:   result_o = opa_i ^ opb_i;
                K_OR:    result_o = opa_i | opb_i;
                K_AND:   result_o = opa_i & opb_i;
                default: result_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/rv64_alu_checker.sv
// Module: port-level property checker for the execute unit, bound to the top.
// Assumes: combinational block, so checks are immediate and settle-time based.
module rv64_alu_checker #(
    parameter int XLEN = 64
) (
    input logic [3:0]      op_sel_i,
    input logic            word_i,
    input logic [XLEN-1:0] opa_i,
    input logic [XLEN-1:0] opb_i,
    input logic [XLEN-1:0] pc_i,
    input logic [XLEN-1:0] result_o
);
    logic [2:0] k;
    logic       wshift_or_add;
    logic       shift_op;
    logic       zero_amt;

    // Helper decode of the observed select
    always_comb begin
        k             = op_sel_i[2:0];
        shift_op      = (k == 3'd1) || (k == 3'd5);
        wshift_or_add = word_i && (shift_op || (k == 3'd0));
        zero_amt      = word_i ? (opb_i[4:0] == 5'd0) : (opb_i[5:0] == 6'd0);
    end

    // Port relations that must hold for every input
    always_comb begin
        if (wshift_or_add)
            AST_WORD_SEXT: assert (result_o[XLEN-1:32] == {(XLEN-32){result_o[31]}}) // R2
                else $error("word result not sign-extended");
        if ((k == 3'd2 || k == 3'd3) && !op_sel_i[3])
            AST_SLT_BOOLEAN: assert (result_o[XLEN-1:1] == '0) // R6
                else $error("compare result not boolean");
        if (op_sel_i == 4'b1010)
            AST_LUI_LOW_ZERO: assert (result_o[11:0] == 12'd0) // R9
                else $error("upper immediate low bits not zero");
        if (op_sel_i == 4'b1011)
            AST_AUIPC_LOW_PC: assert (result_o[11:0] == pc_i[11:0]) // R10
                else $error("pc-relative low bits changed");
        if (k == 3'd7)
            AST_AND_SUBSET: assert ((result_o & ~opa_i) == '0) // R7
                else $error("and result outside operand A");
        if (shift_op && zero_amt)
            AST_SHIFT_ZERO_AMT: assert (result_o == (word_i ? {{(XLEN-32){opa_i[31]}}, opa_i[31:0]} : opa_i)) // R3
                else $error("zero-amount shift changed operand");
    end
endmodule

bind rv64_exec_alu rv64_alu_checker #(.XLEN(XLEN)) i_rv64_alu_checker (
    .op_sel_i (op_sel_i),
    .word_i   (word_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .pc_i     (pc_i),
    .result_o (result_o)
);

// File: tb/test_rv64_exec_alu.sv
`timescale 1ns/1ps
// Bench: corner-value and shift-amount sweeps with an arithmetic reference.
module test_rv64_exec_alu;
    logic        clk;
    logic        rst_n;
    logic [3:0]  op_sel;
    logic        word;
    logic [63:0] opa;
    logic [63:0] opb;
    logic [63:0] pc;
    logic [63:0] result;
    int          nvec;
    int          nfail;
    bit          done;

    rv64_exec_alu i_rv64_exec_alu (
        .op_sel_i (op_sel),
        .word_i   (word),
        .opa_i    (opa),
        .opb_i    (opb),
        .pc_i     (pc),
        .result_o (result)
    );

    // 100 MHz clock
    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    // Reference model written from the requirements
    function automatic logic [63:0] model(input logic [3:0] op, input logic w,
                                          input logic [63:0] a, input logic [63:0] b,
                                          input logic [63:0] p);
        logic [63:0] u;
        logic [31:0] a32;
        u   = sx32({b[19:0], 12'd0});
        a32 = a[31:0];
        if (op == 4'b1010) return u;
        if (op == 4'b1011) return p + u;
        case (op[2:0])
            3'd0: begin
                if (w) return sx32(op[3] ? (a32 - b[31:0]) : (a32 + b[31:0]));
                return op[3] ? (a - b) : (a + b);
            end
            3'd1: begin
                if (w) return sx32(a32 << b[4:0]);
                return a << b[5:0];
            end
            3'd5: begin
                if (w) return sx32(op[3] ? $unsigned($signed(a32) >>> b[4:0]) : (a32 >> b[4:0]));
                return op[3] ? $unsigned($signed(a) >>> b[5:0]) : (a >> b[5:0]);
            end
            3'd2: return {63'd0, $signed(a) < $signed(b)};
            3'd3: return {63'd0, a < b};
            3'd4: return a ^ b;
            3'd6: return a | b;
            default: return a & b;
        endcase
    endfunction

    function automatic string req_tag(input logic [3:0] op, input logic w);
        if (op == 4'b1010) return "R9";
        if (op == 4'b1011) return "R10";
        case (op[2:0])
            3'd0: return w ? "R2" : "R1";
            3'd1: return w ? "R4" : "R3";
            3'd5: return w ? "R4" : "R5";
            3'd2, 3'd3: return w ? "R8" : "R6";
            default: return w ? "R8" : "R7";
        endcase
    endfunction

    function automatic logic [63:0] corner(input int i);
        case (i)
            0: return 64'd0;
            1: return 64'd1;
            2: return '1;
            3: return 64'h0000_0000_7fff_ffff;
            4: return 64'h0000_0000_8000_0000;
            5: return 64'h0000_0000_ffff_ffff;
            6: return 64'h8000_0000_0000_0000;
            7: return 64'h7fff_ffff_ffff_ffff;
            8: return 64'h0000_0001_0000_0000;
            9: return 64'h1234_5678_9abc_def0;
            10: return 64'hfedc_ba98_7654_3210;
            default: return 64'h0000_003f_8000_001f;
        endcase
    endfunction

    // Drive on the falling edge, compare 2 ns later (zero-register path)
    task automatic apply(input logic [3:0] op, input logic w, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] p, input string why);
        logic [63:0] exp;
        @(negedge clk);
        op_sel = op; word = w; opa = a; opb = b; pc = p;
        #2;
        exp = model(op, w, a, b, p);
        nvec++;
        if (result !== exp) begin
            nfail++;
            $display("FAIL %s op=%b w=%0b a=%h b=%h: actual %h expected %h",
                     why, op, w, a, b, result, exp);
        end
    endtask

    // Watchdog ends a hung run as a failure
    initial begin
        #(150_000 * 10);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        nvec = 0; nfail = 0; done = 1'b0;
        rst_n = 1'b0;
        op_sel = '0; word = 1'b0; opa = '0; opb = '0; pc = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: all-zero inputs give a zero sum (R1, encoding per R11-free code 0)
        apply(4'b0000, 1'b0, 64'd0, 64'd0, 64'd0, "R1");
        // Sign extension of a zero-immediate word add (R2)
        apply(4'b0000, 1'b1, 64'hdead_beef_8000_0001, 64'd0, 64'd0, "R2");
        // Corner-value sweep over every select, both modes
        for (int op = 0; op < 16; op++) begin
            for (int w = 0; w < 2; w++) begin
                for (int i = 0; i < 12; i++) begin
                    for (int j = 0; j < 12; j++) begin
                        apply(op[3:0], w[0], corner(i), corner(j),
                              corner((i + j) % 12), req_tag(op[3:0], w[0]));
                    end
                end
            end
        end
        // Shift-amount sweep with junk above the amount field (R3 R4 R5)
        for (int s = 0; s < 64; s++) begin
            for (int p = 0; p < 3; p++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [63:0] b;
                    b = {58'h2aa_aaaa_aaaa_aaaa, s[5:0]};
                    apply(4'b0001, w[0], corner(9 + p), b, 64'd0, w[0] ? "R4" : "R3");
                    apply(4'b0101, w[0], corner(6 + p), b, 64'd0, w[0] ? "R4" : "R5");
                    apply(4'b1101, w[0], corner(4 + p), b, 64'd0, w[0] ? "R4" : "R5");
                end
            end
        end
        // Upper immediate with and without bit 19 set (R9 R10)
        apply(4'b1010, 1'b1, 64'd0, 64'hffff_ffff_fff8_0001, 64'd0, "R9");
        apply(4'b1011, 1'b0, 64'd0, 64'h0000_0000_0007_ffff, 64'hffff_ffff_ffff_f000, "R10");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule